// File: doc/BRIEF.md
# Two-Stage Pipelined Shift-Add Multiplier

This block multiplies two unsigned operands and returns their full-width unsigned product. The multiplication runs as a chain of identical add-or-pass step cells with no loop and no control. Each cell reads one multiplier bit, starting at the least significant bit. When that bit is 1 it adds the multiplicand to a running sum. The cell then hands the multiplicand, shifted one place toward the more significant end, to the next cell.

Both operands are captured in registers on every clock. A bank of pipeline registers cuts the chain after the first `SPLIT` cells. That bank holds the partial sum, the shifted multiplicand and the multiplier bits not yet used. The product leaves through its own register. The block takes a new operand pair on every clock and returns one product per clock. Its output stream is the unpipelined stream delayed by one extra cycle, and it emits zeros while the second stage fills.

Top module: `smul_pipe2`

## Requirements
- R1: For any 4-bit unsigned `mcand_i` and `mplier_i`, the design produces the exact 8-bit unsigned product `mcand_i * mplier_i`.
- R2: A pair presented before a rising edge shows up on `prod_o` after the third rising edge from that one. A new pair is accepted on every edge, so back-to-back pairs give back-to-back products.
- R3: While `rst_i` is high at a rising edge, that edge clears every register (operand, pipeline and product) to zero, whatever the operand inputs hold. `prod_o` is 0 after that edge.
- R4: After `rst_i` falls, `prod_o` stays 0 for the first two rising edges, before the first captured pair reaches the output.
- R5: Zero in either operand gives 0. The largest pair, 15 by 15, gives 225 with no carry out of any step cell.
- R6: If reset is asserted for one edge in the middle of a stream, the pairs already in flight are discarded. Those pairs never appear on `prod_o`, and the zero-fill behaviour of R4 repeats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mcand_i | input | OP_W (4) | Multiplicand, unsigned |
| mplier_i | input | OP_W (4) | Multiplier, unsigned |
| prod_o | output | 2*OP_W (8) | Registered product, unsigned |

## Verification
The bench sweeps all 256 operand pairs back to back. This exposes a cell that shifts the multiplicand the wrong way or adds on the wrong multiplier bit, because only some products would then come out wrong. It compares every output against a reference delayed by exactly three edges. A pipeline with a missing or an extra register bank would therefore show every product one slot early or late. Nonzero operands held during reset, and a reset pulse in mid-stream, catch a reset that misses a register: stale products would leak out during the zero-fill window. The 15-by-15 pair catches a truncated sum or multiplicand that drops the top product bit.

// File: rtl/smul_pkg.sv
package smul_pkg;
  // Default operand width and default stage-one step count.
  localparam int unsigned SMUL_OP_W  = 4;
  localparam int unsigned SMUL_SPLIT = 2;
  // Latency in edges from the operand inputs to prod_o.
  localparam int unsigned SMUL_LAT   = 3;
endpackage

// File: rtl/smul_step.sv
module smul_step #(
  parameter int unsigned PW = 8
) (
  input  logic          mbit_i,
  input  logic [PW-1:0] psum_i,
  input  logic [PW-1:0] mcand_i,
  output logic [PW-1:0] psum_o,
  output logic [PW-1:0] mcand_o,
  output logic          carry_o
);
  // Add-or-pass on one multiplier bit, one bit wider to expose the carry.
  function automatic logic [PW:0] add_or_pass(input logic take,
                                              input logic [PW-1:0] s,
                                              input logic [PW-1:0] m);
    return take ? ({1'b0, s} + {1'b0, m}) : {1'b0, s};
  endfunction

  logic [PW:0] full_w;
  assign full_w  = add_or_pass(mbit_i, psum_i, mcand_i);
  assign psum_o  = full_w[PW-1:0];
  assign carry_o = full_w[PW];
  assign mcand_o = mcand_i << 1;
endmodule

// File: rtl/smul_stage.sv
module smul_stage #(
  parameter int unsigned PW    = 8,
  parameter int unsigned NSTEP = 2
) (
  input  logic [PW-1:0]    psum_i,
  input  logic [PW-1:0]    mcand_i,
  input  logic [NSTEP-1:0] mbits_i,
  output logic [PW-1:0]    psum_o,
  output logic [PW-1:0]    mcand_o,
  output logic             carry_o
);
  logic [PW-1:0]    ps_w [NSTEP+1];
  logic [PW-1:0]    mc_w [NSTEP+1];
  logic [NSTEP-1:0] cy_w;

  assign ps_w[0] = psum_i;
  assign mc_w[0] = mcand_i;

  for (genvar i = 0; i < NSTEP; i++) begin : g_cell
    smul_step #(.PW(PW)) u_step (
      .mbit_i (mbits_i[i]),
      .psum_i (ps_w[i]),
      .mcand_i(mc_w[i]),
      .psum_o (ps_w[i+1]),
      .mcand_o(mc_w[i+1]),
      .carry_o(cy_w[i])
    );
  end

  assign psum_o  = ps_w[NSTEP];
  assign mcand_o = mc_w[NSTEP];
  assign carry_o = |cy_w;
endmodule

// File: rtl/smul_pipe2.sv
module smul_pipe2 #(
  parameter int unsigned OP_W  = smul_pkg::SMUL_OP_W,
  parameter int unsigned SPLIT = smul_pkg::SMUL_SPLIT
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [OP_W-1:0]   mcand_i,
  input  logic [OP_W-1:0]   mplier_i,
  output logic [2*OP_W-1:0] prod_o
);
  localparam int unsigned PW   = 2 * OP_W;
  localparam int unsigned REST = OP_W - SPLIT;

  // Operand registers.
  logic [OP_W-1:0] opa_q, opb_q;
  // Pipeline bank between the two stages.
  logic [PW-1:0]   pipe_psum_q, pipe_mcand_q;
  logic [REST-1:0] pipe_bits_q;
  // Product register.
  logic [PW-1:0]   prod_q;

  // Stage results, brought out for the assertions.
  logic [PW-1:0] s1_psum_w, s1_mcand_w, s2_psum_w, s2_mcand_w;
  logic          s1_carry_w, s2_carry_w;

  smul_stage #(.PW(PW), .NSTEP(SPLIT)) u_stage1 (
    .psum_i ('0),
    .mcand_i(PW'(opa_q)),
    .mbits_i(opb_q[SPLIT-1:0]),
    .psum_o (s1_psum_w),
    .mcand_o(s1_mcand_w),
    .carry_o(s1_carry_w)
  );

  smul_stage #(.PW(PW), .NSTEP(REST)) u_stage2 (
    .psum_i (pipe_psum_q),
    .mcand_i(pipe_mcand_q),
    .mbits_i(pipe_bits_q),
    .psum_o (s2_psum_w),
    .mcand_o(s2_mcand_w),
    .carry_o(s2_carry_w)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      opa_q        <= '0;
      opb_q        <= '0;
      pipe_psum_q  <= '0;
      pipe_mcand_q <= '0;
      pipe_bits_q  <= '0;
      prod_q       <= '0;
    end else begin
      opa_q        <= mcand_i;
      opb_q        <= mplier_i;
      pipe_psum_q  <= s1_psum_w;
      pipe_mcand_q <= s1_mcand_w;
      pipe_bits_q  <= opb_q[OP_W-1:SPLIT];
      prod_q       <= s2_psum_w;
    end
  end

  assign prod_o = prod_q;

  // Edges since reset, saturating at the latency; used by the assertions only.
  logic [1:0] fill_q;
  always_ff @(posedge clk_i) begin
    if (rst_i)             fill_q <= '0;
    else if (fill_q != 2'd3) fill_q <= fill_q + 2'd1;
  end

  logic [PW-1:0] s2_mcand_unused_w;
  assign s2_mcand_unused_w = s2_mcand_w;

  AST_PRODUCT_LATENCY: assert property (@(posedge clk_i) disable iff (rst_i)
    (fill_q == 2'd3) |-> (prod_o == PW'($past(mcand_i, 3)) * PW'($past(mplier_i, 3)))); // R1
  AST_ZERO_FILL: assert property (@(posedge clk_i) disable iff (rst_i)
    (fill_q != 2'd3) |-> (prod_o == '0)); // R4
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    $past(rst_i) |-> (prod_o == '0 && pipe_psum_q == '0 && opa_q == '0)); // R3
  AST_MCAND_FORWARD: assert property (@(posedge clk_i) disable iff (rst_i)
    (fill_q != 2'd0) |-> (pipe_mcand_q == (PW'($past(opa_q)) << SPLIT))); // R2
  AST_BITS_FORWARD: assert property (@(posedge clk_i) disable iff (rst_i)
    (fill_q != 2'd0) |-> (pipe_bits_q == $past(opb_q[OP_W-1:SPLIT]))); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
    !(s1_carry_w || s2_carry_w || s2_mcand_unused_w[0])); // R5
endmodule

// File: tb/sim_smul_pipe2.sv
module sim_smul_pipe2;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] a, b;
  logic [7:0] prod;

  int n_vec  = 0;
  int n_fail = 0;
  logic [7:0] hist [3];

  smul_pipe2 u0 (.clk_i(clk), .rst_i(rst), .mcand_i(a), .mplier_i(b), .prod_o(prod));

  always #5 clk = ~clk;

  // Corner-case table: {multiplicand, multiplier}.
  localparam logic [7:0] CORNER [12] = '{
    8'h00, 8'hF0, 8'h0F, 8'hFF, 8'h11, 8'h1F,
    8'hF1, 8'h88, 8'h84, 8'h48, 8'hA5, 8'h5A
  };

  // Reference by repeated addition.
  function automatic logic [7:0] ref_mul(input logic [3:0] x, input logic [3:0] y);
    logic [7:0] acc = 8'd0;
    for (int k = 0; k < 16; k++) if (k < int'(y)) acc = acc + {4'd0, x};
    return acc;
  endfunction

  // At a falling edge: check the output against the reference from three pairs back,
  // then drive the next pair and reset level.
  task automatic apply(input logic [3:0] x, input logic [3:0] y, input logic r, input string tag);
    @(negedge clk);
    n_vec++;
    if (prod !== hist[2]) begin
      n_fail++;
      $display("FAIL %s: prod=%0d expected=%0d", tag, prod, hist[2]);
    end
    a = x; b = y; rst = r;
    hist[2] = hist[1];
    hist[1] = hist[0];
    hist[0] = ref_mul(x, y);
    if (r) begin
      hist[0] = 8'd0; hist[1] = 8'd0; hist[2] = 8'd0;
    end
  endtask

  initial begin
    rst = 1'b1; a = 4'hF; b = 4'hF;
    hist[0] = 8'd0; hist[1] = 8'd0; hist[2] = 8'd0;
    // R3: reset with nonzero operands held.
    apply(4'hF, 4'hF, 1'b1, "R3 reset");
    apply(4'hF, 4'hF, 1'b1, "R3 reset");
    // Release; the next two checks are the zero fill (R4).
    apply(4'hF, 4'hF, 1'b0, "R3 reset");
    apply(4'h7, 4'h3, 1'b0, "R4 zero fill");
    apply(4'h3, 4'h7, 1'b0, "R4 zero fill");
    // Corner table: zeros, max, single bits (R5, R1).
    for (int i = 0; i < 12; i++)
      apply(CORNER[i][7:4], CORNER[i][3:0], 1'b0, "R5 corner");
    // Full sweep back to back (R1, R2).
    for (int i = 0; i < 256; i++)
      apply(i[7:4], i[3:0], 1'b0, "R1/R2 sweep");
    // R6: reset pulse mid-stream, then refill.
    apply(4'hE, 4'hD, 1'b0, "R2 stream");
    apply(4'hC, 4'hB, 1'b1, "R2 stream");
    apply(4'h9, 4'h9, 1'b0, "R6 flush");
    apply(4'h2, 4'h5, 1'b0, "R6 flush");
    apply(4'h0, 4'h0, 1'b0, "R6 flush");
    for (int i = 0; i < 4; i++)
      apply(4'h0, 4'h0, 1'b0, "R2 drain");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule